// File: doc/BRIEF.md
# Parallel Display Bus Bridge

This block sits on a processor's memory-mapped bus as a slave and turns register accesses into byte transfers on an 8-bit, 8080-style parallel bus to a TFT display controller. It has three registers. The command register takes one byte, and panel transfers through it run with the register-select line low. The pixel/data register accepts 1 to 8 bytes per access, and panel transfers through it run with the register-select line high. A one-byte pin-control register lets software take over the lines the panel shares with a resistive touchscreen. It can force each of those lines high or low, or release it.

A multi-byte write is broken into single-byte write strobes. The bytes go out in pair-swapped lane order, so a 16-bit pixel placed little-endian on the bus reaches the panel with its most-significant byte first. A read of the command or data register performs one panel read strobe and returns the byte on all eight bus lanes. For this reason, reads at any byte offset inside a register give the same value. The bus acknowledge stays low until the last panel transfer of the access has finished, so the processor stalls for the whole sequence.

The master follows a request/acknowledge handshake. It holds `bus_req` and the address, select and write data stable until it sees `bus_ack`, and then drops `bus_req`. Register decode uses `bus_adr[4:3]`: 0 selects the command register, 1 selects the data register, 2 selects pin control, and 3 is unused.

Top module: `lcd_bus_bridge`

## Requirements
- R1: A write to the data register sends one write strobe for each byte lane whose select bit is set. Lanes are visited in the order 1,0,3,2,5,4,7,6, unselected lanes are skipped, and the panel data pins carry that lane's byte (bits 8k+7..8k) during the strobe.
- R2: During every strobe, the register-select pin is low for accesses to the command register (`bus_adr[4:3]`=0) and high for accesses to the data register (`bus_adr[4:3]`=1), unless the pin-control register overrides it.
- R3: A command register write uses only lane 0 (`bus_sel[0]`, `bus_wdata[7:0]`) and sends at most one strobe. With `bus_sel[0]`=0 it sends no strobe and is still acknowledged.
- R4: A read of the command or data register at any byte offset performs exactly one read strobe. The returned `bus_rdata` holds the panel byte replicated on all 8 lanes.
- R5: For every strobe, chip select is low for SETUP_CYC cycles before the strobe falls. The strobe stays low for exactly STROBE_CYC cycles, and chip select stays low for HOLD_CYC cycles after the strobe rises. Chip select is high between accesses.
- R6: While the read strobe is low, the data pin output enables are off (except pins under override). The byte returned is the value on `lcd_d_i` in the last strobe cycle.
- R7: `bus_ack` is a one-cycle pulse given only after the last strobe of the access has completed. No strobe occurs after it until a new request arrives.
- R8: The pin-control register (`bus_adr[4:3]`=2) is written from `bus_wdata[7:0]` when `bus_sel[0]`=1, causes no panel strobe, and reads back replicated on all 8 lanes.
- R9: Pin-control fields are 2 bits each: bits 1:0 for register-select, 3:2 for data pin 0, 5:4 for data pin 1, and 7:6 for chip select. The codes are 00 normal, 01 released (output enable off), 10 driven low, and 11 driven high. A non-zero code takes priority over the normal drive of that pin, including during transfers.
- R10: After reset, `bus_ack` is 0, the write and read strobes and chip select are high, all data and control output enables are on, and the pin-control register is zero.
- R11: The write and read strobes are never low together, and the data pins do not change while the write strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_adr | input | 5 | Byte offset; bits 4:3 select the register |
| bus_sel | input | 8 | Byte-lane selects |
| bus_wdata | input | 64 | Write data, lane k in bits 8k+7..8k |
| bus_rdata | output | 64 | Read data |
| bus_ack | output | 1 | One-cycle completion pulse |
| lcd_d_i | input | 8 | Panel data pins, input side |
| lcd_d_o | output | 8 | Panel data pins, output side |
| lcd_d_oe | output | 8 | Panel data pin output enables |
| lcd_rs_o | output | 1 | Register-select level |
| lcd_rs_oe | output | 1 | Register-select output enable |
| lcd_cs_n_o | output | 1 | Chip-select level (active low) |
| lcd_cs_oe | output | 1 | Chip-select output enable |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rd_n | output | 1 | Read strobe, active low |

## Verification
The bench sweeps all 256 lane-select masks on the data register and compares the strobed byte stream against the pair-swapped order built in the bench. A design that walked the lanes straight, or that sent unselected lanes, would show wrong bytes or a wrong strobe count. It also sweeps all 256 pin-control codes on every overridable pin, which catches a swapped field, a mixed-up code, or normal drive winning over an override. Command-register writes with lane 0 off, reads at non-zero offsets, and an override held across a data write cover the edge cases of lane filtering, byte replication and override priority. Every strobe's setup, width and hold are timed, so an off-by-one in any phase counter shows up as a timing mismatch.

// File: rtl/lcd_bridge_pkg.sv
// Package: shared state encodings and pin-override helper for the display bridge.
// Assumes: override codes are 2 bits per pin, 00 = no override.
package lcd_bridge_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE   = 2'd0,
        ENG_SETUP  = 2'd1,
        ENG_STROBE = 2'd2,
        ENG_HOLD   = 2'd3
    } eng_state_t;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2,
        SEQ_ACK   = 2'd3
    } seq_state_t;

    typedef logic [1:0] pin_mode_t;
    localparam pin_mode_t PM_NORMAL  = 2'b00;
    localparam pin_mode_t PM_RELEASE = 2'b01;
    localparam pin_mode_t PM_LOW     = 2'b10;
    localparam pin_mode_t PM_HIGH    = 2'b11;

    // register decode on bus_adr[4:3]
    localparam logic [1:0] REG_CMD   = 2'd0;
    localparam logic [1:0] REG_DATA  = 2'd1;
    localparam logic [1:0] REG_PINS  = 2'd2;

    // returns {level, output_enable} for one pin after override
    function automatic logic [1:0] pin_apply(input pin_mode_t mode,
                                             input logic norm_val,
                                             input logic norm_oe);
        case (mode)
            PM_RELEASE: pin_apply = {norm_val, 1'b0};
            PM_LOW:     pin_apply = 2'b01;
            PM_HIGH:    pin_apply = 2'b11;
            default:    pin_apply = {norm_val, norm_oe};
        endcase
    endfunction

endpackage

// File: rtl/lcd_lane_pick.sv
// Module: lcd_lane_pick
// Picks the next byte lane to send from a pending-lane mask, walking the
// lanes in pair-swapped order (1,0,3,2,...). Purely combinational.
// Assumes: NLANES is even.
module lcd_lane_pick #(
    parameter int NLANES = 8,
    localparam int LW = $clog2(NLANES)
) (
    input  logic [NLANES-1:0] pend,
    output logic              found,
    output logic [LW-1:0]     lane
);
    // scan from the last position down so the earliest position wins
    always_comb begin
        found = 1'b0;
        lane  = '0;
        for (int p = NLANES - 1; p >= 0; p--) begin
            if (pend[p ^ 1]) begin
                found = 1'b1;
                lane  = LW'(p ^ 1);
            end
        end
    end
endmodule

// File: rtl/lcd_strobe_engine.sv
// Module: lcd_strobe_engine
// Runs one panel byte transfer: chip select low for a setup phase, a
// write or read strobe for STROBE_CYC cycles, then a hold phase. It pulses
// done for one cycle when it returns to idle. A read captures d_in on the
// last strobe cycle.
// Assumes: start is only given while idle; all cycle counts >= 1.
module lcd_strobe_engine
    import lcd_bridge_pkg::*;
#(
    parameter int SETUP_CYC  = 2,
    parameter int STROBE_CYC = 3,
    parameter int HOLD_CYC   = 1,
    localparam int MAXC = (SETUP_CYC > STROBE_CYC) ?
                          ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                          ((STROBE_CYC > HOLD_CYC) ? STROBE_CYC : HOLD_CYC),
    localparam int CW = $clog2(MAXC + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       is_read,
    input  logic       rs_in,
    input  logic [7:0] wbyte,
    input  logic [7:0] d_in,
    output logic       done,
    output logic [7:0] rbyte,
    output logic       cs_n,
    output logic       wr_n,
    output logic       rd_n,
    output logic       rs,
    output logic [7:0] d_o,
    output logic [7:0] d_oe
);
    eng_state_t    st;
    logic [CW-1:0] cnt;
    logic          rd_q;

    // phase sequencing, counters and captured values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ENG_IDLE;
            cnt   <= '0;
            rd_q  <= 1'b0;
            done  <= 1'b0;
            rbyte <= '0;
            rs    <= 1'b1;
            d_o   <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                ENG_IDLE: begin
                    if (start) begin
                        st   <= ENG_SETUP;
                        cnt  <= CW'(SETUP_CYC - 1);
                        rd_q <= is_read;
                        rs   <= rs_in;
                        if (!is_read) d_o <= wbyte;
                    end
                end
                ENG_SETUP: begin
                    if (cnt == '0) begin
                        st  <= ENG_STROBE;
                        cnt <= CW'(STROBE_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ENG_STROBE: begin
                    if (cnt == '0) begin
                        st  <= ENG_HOLD;
                        cnt <= CW'(HOLD_CYC - 1);
                        if (rd_q) rbyte <= d_in;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        st   <= ENG_IDLE;
                        done <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    // pin levels decoded from the phase
    always_comb begin
        cs_n = (st == ENG_IDLE);
        wr_n = !((st == ENG_STROBE) && !rd_q);
        rd_n = !((st == ENG_STROBE) && rd_q);
        d_oe = (rd_q && (st != ENG_IDLE)) ? 8'h00 : 8'hFF;
    end
endmodule

// File: rtl/lcd_pin_mux.sv
// Module: lcd_pin_mux
// Applies the pin-control register on top of the normal panel drive for
// register-select, data pins 0 and 1, and chip select.
// Assumes: cfg fields are [1:0] RS, [3:2] D0, [5:4] D1, [7:6] CS.
module lcd_pin_mux
    import lcd_bridge_pkg::*;
(
    input  logic [7:0] cfg,
    input  logic       rs_n_val,
    input  logic       cs_n_val,
    input  logic [7:0] d_val,
    input  logic [7:0] d_en,
    output logic       rs_o,
    output logic       rs_oe,
    output logic       cs_n_o,
    output logic       cs_oe,
    output logic [7:0] d_o,
    output logic [7:0] d_oe
);
    logic [1:0] rs_r, cs_r, d0_r, d1_r;

    // override resolution per pin
    always_comb begin
        rs_r = pin_apply(cfg[1:0], rs_n_val, 1'b1);
        d0_r = pin_apply(cfg[3:2], d_val[0], d_en[0]);
        d1_r = pin_apply(cfg[5:4], d_val[1], d_en[1]);
        cs_r = pin_apply(cfg[7:6], cs_n_val, 1'b1);
        rs_o   = rs_r[1];
        rs_oe  = rs_r[0];
        cs_n_o = cs_r[1];
        cs_oe  = cs_r[0];
        d_o    = {d_val[7:2], d1_r[1], d0_r[1]};
        d_oe   = {d_en[7:2], d1_r[0], d0_r[0]};
    end
endmodule

// File: rtl/lcd_bus_bridge.sv
// Module: lcd_bus_bridge (top)
// Bus slave that converts command/data register accesses into 8-bit panel
// strobes. Writes go out in pair-swapped lane order; reads return one panel
// byte replicated on every lane. It also holds the pin-control override
// register.
// Assumes: the master holds req/adr/sel/wdata stable until bus_ack and
// drops bus_req right after it.
module lcd_bus_bridge
    import lcd_bridge_pkg::*;
#(
    parameter int NLANES     = 8,
    parameter int SETUP_CYC  = 2,
    parameter int STROBE_CYC = 3,
    parameter int HOLD_CYC   = 1,
    localparam int DW = NLANES * 8,
    localparam int LW = $clog2(NLANES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_req,
    input  logic          bus_we,
    input  logic [4:0]    bus_adr,
    input  logic [NLANES-1:0] bus_sel,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_ack,
    input  logic [7:0]    lcd_d_i,
    output logic [7:0]    lcd_d_o,
    output logic [7:0]    lcd_d_oe,
    output logic          lcd_rs_o,
    output logic          lcd_rs_oe,
    output logic          lcd_cs_n_o,
    output logic          lcd_cs_oe,
    output logic          lcd_wr_n,
    output logic          lcd_rd_n
);
    seq_state_t        st;
    logic [NLANES-1:0] pend;
    logic [NLANES-1:0] pend_after;
    logic [NLANES-1:0] pend_init;
    logic              rd_op;
    logic              rs_q;
    logic [7:0]        touch_q;
    logic [DW-1:0]     rdata_q;

    logic              lane_found;
    logic [LW-1:0]     lane;
    logic              eng_start;
    logic              eng_done;
    logic [7:0]        eng_rbyte;
    logic              eng_cs_n, eng_rs;
    logic [7:0]        eng_d_o, eng_d_oe;

    lcd_lane_pick #(.NLANES(NLANES)) u_pick (
        .pend  (pend),
        .found (lane_found),
        .lane  (lane)
    );

    lcd_strobe_engine #(
        .SETUP_CYC (SETUP_CYC),
        .STROBE_CYC(STROBE_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (eng_start),
        .is_read(rd_op),
        .rs_in  (rs_q),
        .wbyte  (bus_wdata[lane*8 +: 8]),
        .d_in   (lcd_d_i),
        .done   (eng_done),
        .rbyte  (eng_rbyte),
        .cs_n   (eng_cs_n),
        .wr_n   (lcd_wr_n),
        .rd_n   (lcd_rd_n),
        .rs     (eng_rs),
        .d_o    (eng_d_o),
        .d_oe   (eng_d_oe)
    );

    lcd_pin_mux u_mux (
        .cfg     (touch_q),
        .rs_n_val(eng_rs),
        .cs_n_val(eng_cs_n),
        .d_val   (eng_d_o),
        .d_en    (eng_d_oe),
        .rs_o    (lcd_rs_o),
        .rs_oe   (lcd_rs_oe),
        .cs_n_o  (lcd_cs_n_o),
        .cs_oe   (lcd_cs_oe),
        .d_o     (lcd_d_o),
        .d_oe    (lcd_d_oe)
    );

    // lanes to send for a new access: command uses lane 0 only, reads one byte
    always_comb begin
        if (!bus_we)
            pend_init = NLANES'(1);
        else if (bus_adr[4:3] == REG_CMD)
            pend_init = {{(NLANES-1){1'b0}}, bus_sel[0]};
        else
            pend_init = bus_sel;
        pend_after = pend & ~(NLANES'(1) << lane);
    end

    // access sequencer: decode, per-byte issue, completion and acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= SEQ_IDLE;
            pend    <= '0;
            rd_op   <= 1'b0;
            rs_q    <= 1'b1;
            touch_q <= '0;
            rdata_q <= '0;
        end else begin
            case (st)
                SEQ_IDLE: begin
                    if (bus_req) begin
                        rd_op <= !bus_we;
                        case (bus_adr[4:3])
                            REG_CMD, REG_DATA: begin
                                rs_q <= (bus_adr[4:3] == REG_DATA);
                                pend <= pend_init;
                                st   <= (pend_init == '0) ? SEQ_ACK : SEQ_ISSUE;
                            end
                            REG_PINS: begin
                                if (bus_we && bus_sel[0]) touch_q <= bus_wdata[7:0];
                                if (!bus_we) rdata_q <= {NLANES{touch_q}};
                                st <= SEQ_ACK;
                            end
                            default: begin
                                if (!bus_we) rdata_q <= '0;
                                st <= SEQ_ACK;
                            end
                        endcase
                    end
                end
                SEQ_ISSUE: st <= SEQ_WAIT;
                SEQ_WAIT: begin
                    if (eng_done) begin
                        if (rd_op) rdata_q <= {NLANES{eng_rbyte}};
                        pend <= pend_after;
                        st   <= (pend_after == '0) ? SEQ_ACK : SEQ_ISSUE;
                    end
                end
                default: st <= SEQ_IDLE;
            endcase
        end
    end

    // handshake outputs
    always_comb begin
        eng_start = (st == SEQ_ISSUE) && lane_found;
        bus_ack   = (st == SEQ_ACK);
        bus_rdata = rdata_q;
    end
endmodule

// File: rtl/lcd_bus_bridge_chk.sv
// Module: lcd_bus_bridge_chk
// Property checker for lcd_bus_bridge, attached by bind below.
// Assumes: touch_cfg is the bridge's pin-control register.
module lcd_bus_bridge_chk #(
    parameter int STROBE_CYC = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_ack,
    input logic       lcd_wr_n,
    input logic       lcd_rd_n,
    input logic       lcd_cs_n_o,
    input logic       lcd_cs_oe,
    input logic [7:0] lcd_d_o,
    input logic [7:0] lcd_d_oe,
    input logic       lcd_rs_oe,
    input logic       lcd_rs_o,
    input logic [7:0] touch_cfg
);
    logic [15:0] low_cnt;
    logic        strobe_lo;

    assign strobe_lo = !lcd_wr_n || !lcd_rd_n;

    // counts cycles the active strobe has been low
    always_ff @(posedge clk) begin
        if (!rst_n)         low_cnt <= '0;
        else if (strobe_lo) low_cnt <= low_cnt + 1'b1;
        else                low_cnt <= '0;
    end

    p_no_dual_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!lcd_wr_n && !lcd_rd_n));

    p_wr_data_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_wr_n && $past(!lcd_wr_n)) |-> $stable(lcd_d_o));

    p_strobe_in_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_lo && touch_cfg[7:6] == 2'b00) |-> (!lcd_cs_n_o && lcd_cs_oe));

    p_strobe_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(strobe_lo) && !strobe_lo) |-> (low_cnt == 16'(STROBE_CYC)));

    p_read_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_rd_n |-> (lcd_d_oe[7:2] == 6'b0));

    p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    p_ack_no_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> (lcd_wr_n && lcd_rd_n));

    p_rs_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_cfg[1:0] == 2'b01) |-> !lcd_rs_oe);

    p_rs_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_cfg[1:0] == 2'b10) |-> (!lcd_rs_o && lcd_rs_oe));

    p_cs_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_cfg[7:6] == 2'b11) |-> (lcd_cs_n_o && lcd_cs_oe));
endmodule

bind lcd_bus_bridge lcd_bus_bridge_chk #(.STROBE_CYC(STROBE_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_ack   (bus_ack),
    .lcd_wr_n  (lcd_wr_n),
    .lcd_rd_n  (lcd_rd_n),
    .lcd_cs_n_o(lcd_cs_n_o),
    .lcd_cs_oe (lcd_cs_oe),
    .lcd_d_o   (lcd_d_o),
    .lcd_d_oe  (lcd_d_oe),
    .lcd_rs_oe (lcd_rs_oe),
    .lcd_rs_o  (lcd_rs_o),
    .touch_cfg (touch_q)
);

// File: tb/lcd_bus_bridge_tb.sv
// Bench for lcd_bus_bridge: sweeps lane masks and pin-control codes,
// logs every panel strobe at the falling clock edge, and compares against
// expectations computed from the requirements.
module lcd_bus_bridge_tb;
    localparam int SETUP_CYC  = 2;
    localparam int STROBE_CYC = 3;
    localparam int HOLD_CYC   = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_adr = '0;
    logic [7:0]  bus_sel = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        bus_ack;
    logic [7:0]  lcd_d_i = '0;
    logic [7:0]  lcd_d_o, lcd_d_oe;
    logic        lcd_rs_o, lcd_rs_oe, lcd_cs_n_o, lcd_cs_oe, lcd_wr_n, lcd_rd_n;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    lcd_bus_bridge #(
        .NLANES(8), .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_adr(bus_adr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .lcd_d_i(lcd_d_i),
        .lcd_d_o(lcd_d_o), .lcd_d_oe(lcd_d_oe), .lcd_rs_o(lcd_rs_o),
        .lcd_rs_oe(lcd_rs_oe), .lcd_cs_n_o(lcd_cs_n_o), .lcd_cs_oe(lcd_cs_oe),
        .lcd_wr_n(lcd_wr_n), .lcd_rd_n(lcd_rd_n)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // strobe log (circular) and timing monitor
    logic [7:0] log_d  [64];
    logic       log_rs [64];
    logic       log_rd [64];
    int  log_n = 0;
    logic prev_strobe = 1'b0;
    int  cs_run = 0, lo_run = 0, hold_run = 0;
    bit  in_hold = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            logic strobe;
            strobe = !lcd_wr_n || !lcd_rd_n;
            if (strobe && !prev_strobe) begin
                check(cs_run == SETUP_CYC, "R5 setup", cs_run, SETUP_CYC);
                log_d[log_n % 64]  = lcd_d_o;
                log_rs[log_n % 64] = lcd_rs_o;
                log_rd[log_n % 64] = !lcd_rd_n;
                log_n++;
                lo_run = 0;
            end
            if (!lcd_rd_n)
                check(lcd_d_oe == 8'h00, "R6 release", lcd_d_oe, 0);
            if (strobe) lo_run++;
            if (!strobe && prev_strobe) begin
                check(lo_run == STROBE_CYC, "R5 width", lo_run, STROBE_CYC);
                in_hold  = 1;
                hold_run = 0;
            end
            if (in_hold) begin
                if (!lcd_cs_n_o) hold_run++;
                else begin
                    check(hold_run == HOLD_CYC, "R5 hold", hold_run, HOLD_CYC);
                    in_hold = 0;
                end
            end
            if (!lcd_cs_n_o && !strobe) cs_run++;
            else if (lcd_cs_n_o) cs_run = 0;
            prev_strobe = strobe;
        end
    end

    task automatic bus_do(input logic we, input logic [4:0] adr, input logic [7:0] sel,
                          input logic [63:0] wd, output logic [63:0] rd);
        int t = 0;
        @(negedge clk);
        bus_req = 1; bus_we = we; bus_adr = adr; bus_sel = sel; bus_wdata = wd;
        @(negedge clk);
        while (!bus_ack && t < 2000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 2000) check(0, "R7 ack timeout", t, 0);
        rd = bus_rdata;
        bus_req = 0;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            check(0, "watchdog", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] rd;
        logic [63:0] wd;
        logic [7:0]  exp_b [8];
        int n, base;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        check(!bus_ack && lcd_wr_n && lcd_rd_n && lcd_cs_n_o && lcd_cs_oe &&
              lcd_rs_oe && lcd_d_oe == 8'hFF, "R10 reset pins",
              {bus_ack, lcd_wr_n, lcd_rd_n, lcd_cs_n_o, lcd_cs_oe, lcd_rs_oe, lcd_d_oe},
              {6'b011111, 8'hFF});
        rst_n = 1;
        bus_do(0, 5'h10, 8'h01, 0, rd);
        check(rd == 64'h0, "R10 pin-control reset", rd, 0);

        // R1 R2 R7: sweep all lane masks on the data register
        for (int m = 0; m < 256; m++) begin
            for (int i = 0; i < 8; i++) wd[i*8 +: 8] = 8'(m * 7 + i * 37 + 3);
            n = 0;
            for (int p = 0; p < 8; p++)
                if (m[p ^ 1]) begin exp_b[n] = wd[(p ^ 1)*8 +: 8]; n++; end
            base = log_n;
            bus_do(1, 5'h08, 8'(m), wd, rd);
            check(log_n - base == n, "R7 strobes done at ack", log_n - base, n);
            repeat (3) @(negedge clk);
            check(log_n - base == n, "R1 strobe count", log_n - base, n);
            for (int k = 0; k < n && k < 8; k++) begin
                check(log_d[(base + k) % 64] == exp_b[k] && !log_rd[(base + k) % 64],
                      "R1 byte order", log_d[(base + k) % 64], exp_b[k]);
                check(log_rs[(base + k) % 64] == 1'b1, "R2 data rs high",
                      log_rs[(base + k) % 64], 1);
            end
        end

        // R3 R2: command writes use lane 0 only
        base = log_n;
        bus_do(1, 5'h00, 8'hFF, 64'h1122334455667788, rd);
        check(log_n - base == 1, "R3 one strobe", log_n - base, 1);
        check(log_d[base % 64] == 8'h88, "R3 lane0 byte", log_d[base % 64], 8'h88);
        check(log_rs[base % 64] == 1'b0, "R2 command rs low", log_rs[base % 64], 0);
        base = log_n;
        bus_do(1, 5'h00, 8'hFE, 64'hFFFF_FFFF_FFFF_FFFF, rd);
        repeat (3) @(negedge clk);
        check(log_n - base == 0, "R3 no strobe without lane0", log_n - base, 0);

        // R4 R6: reads at various offsets
        for (int j = 0; j < 16; j++) begin
            logic [4:0] adr;
            logic [7:0] v;
            adr = (j < 8) ? 5'(j) : 5'(8 + (j - 8));
            v = 8'(j * 29 + 90);
            lcd_d_i = v;
            base = log_n;
            bus_do(0, adr, 8'hFF, 0, rd);
            check(rd == {8{v}}, "R4 read replicated", rd, {8{v}});
            check(log_n - base == 1 && log_rd[base % 64], "R4 one read strobe",
                  log_n - base, 1);
            check(log_rs[base % 64] == (j >= 8), "R2 read rs", log_rs[base % 64], (j >= 8));
        end

        // unused register address: acknowledged, no strobe
        base = log_n;
        bus_do(1, 5'h18, 8'hFF, 64'hFFFF, rd);
        repeat (3) @(negedge clk);
        check(log_n - base == 0, "R7 unused addr no strobe", log_n - base, 0);

        // known idle drive: data byte A6 with rs high
        bus_do(1, 5'h08, 8'h01, 64'hA6, rd);

        // R8 R9: sweep all pin-control codes
        for (int c = 0; c < 256; c++) begin
            logic [1:0] mr, m0, m1, mc;
            bit ok;
            base = log_n;
            bus_do(1, 5'h10, 8'h01, {56'hFFFF_FFFF_FFFF_FF, 8'(c)}, rd);
            @(negedge clk);
            check(log_n == base, "R8 no strobe on pin write", log_n - base, 0);
            mr = 2'(c); m0 = 2'(c >> 2); m1 = 2'(c >> 4); mc = 2'(c >> 6);
            ok = 1;
            case (mr)
                2'b00: ok &= (lcd_rs_o == 1 && lcd_rs_oe);
                2'b01: ok &= !lcd_rs_oe;
                2'b10: ok &= (lcd_rs_o == 0 && lcd_rs_oe);
                default: ok &= (lcd_rs_o == 1 && lcd_rs_oe);
            endcase
            case (m0)
                2'b00: ok &= (lcd_d_o[0] == 0 && lcd_d_oe[0]);
                2'b01: ok &= !lcd_d_oe[0];
                2'b10: ok &= (lcd_d_o[0] == 0 && lcd_d_oe[0]);
                default: ok &= (lcd_d_o[0] == 1 && lcd_d_oe[0]);
            endcase
            case (m1)
                2'b00: ok &= (lcd_d_o[1] == 1 && lcd_d_oe[1]);
                2'b01: ok &= !lcd_d_oe[1];
                2'b10: ok &= (lcd_d_o[1] == 0 && lcd_d_oe[1]);
                default: ok &= (lcd_d_o[1] == 1 && lcd_d_oe[1]);
            endcase
            case (mc)
                2'b00: ok &= (lcd_cs_n_o == 1 && lcd_cs_oe);
                2'b01: ok &= !lcd_cs_oe;
                2'b10: ok &= (lcd_cs_n_o == 0 && lcd_cs_oe);
                default: ok &= (lcd_cs_n_o == 1 && lcd_cs_oe);
            endcase
            ok &= (lcd_d_o[7:2] == 6'b101001) && (lcd_d_oe[7:2] == 6'h3F);
            check(ok, "R9 override pins",
                  {lcd_rs_o, lcd_rs_oe, lcd_d_o, lcd_d_oe, lcd_cs_n_o, lcd_cs_oe}, c);
            bus_do(0, 5'(16 + c % 8), 8'hFF, 0, rd);
            check(rd == {8{8'(c)}}, "R8 readback", rd, {8{8'(c)}});
        end

        // R9 override priority during a data transfer
        bus_do(1, 5'h10, 8'h01, 64'h02, rd);
        base = log_n;
        bus_do(1, 5'h08, 8'h03, 64'h5A3C, rd);
        check(log_n - base == 2 && log_rs[base % 64] == 0 && log_rs[(base + 1) % 64] == 0,
              "R9 rs forced low in transfer", log_rs[base % 64], 0);
        bus_do(1, 5'h10, 8'h01, 64'h00, rd);

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule